// File: doc/BRIEF.md
# Two-Bank Valid-Bit Store with Instant Flush

This block holds the per-entry valid flags of a direct-mapped cache. It keeps two equal banks of flags and uses only one of them at a time. The cache controller looks up the flag of an index and sets or clears flags through a single write port. A flush request invalidates every entry at once. The block does this by making the other bank active, because that bank is already all clear. It then wipes the bank it just left, one entry per clock, while lookups and writes go on against the new bank.

While the background wipe runs, the block raises `busy`. A second flush that arrives during a wipe is remembered. It takes effect on the clock edge that clears the last entry, so the bank it switches to is clean, and `busy` stays high without a gap. The lookup output is combinational from the active bank. Writes are accepted on every cycle with no back-pressure. The flush request is a one-cycle strobe, and no strobe is ever refused: it is either carried out at once or held.

Top module: `vbank_flush_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and the lookup returns 0 for every index, with bank 0 active.
- R2: A write with `wr_en`=1 stores `wr_val` at `wr_idx` in the active bank, and a lookup of that index returns it from the cycle after the edge.
- R3: A flush strobe taken while `busy`=0 makes every lookup return 0 from the next cycle on. These are entries set before the flush.
- R4: After a flush taken while idle, `busy` is 1 for exactly 2^IDX_W cycles (1024 by default) and then returns to 0, provided no further flush arrives.
- R5: Writes and lookups work normally on the new active bank while the background wipe is running.
- R6: A flush strobe taken while `busy`=1 is held. The bank switch happens on the edge that wipes the last entry of the old bank, and `busy` stays 1 throughout and through the following wipe.
- R7: When a bank becomes active again, all of its entries read 0, including entries that were set when it was last active.
- R8: A write in the same cycle as a flush taken while idle lands in the bank being retired and is not visible after the flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_idx | input | IDX_W | Lookup index |
| lk_valid | output | 1 | Valid flag of `lk_idx` in the active bank (combinational) |
| wr_en | input | 1 | Write strobe for the active bank |
| wr_idx | input | IDX_W | Write index |
| wr_val | input | 1 | Flag value to store (1 = fill, 0 = invalidate) |
| flush_req | input | 1 | One-cycle flush request |
| busy | output | 1 | A background wipe is running or a flush is held |

## Verification
The bench sets flags in bank 0 and then flushes. A design that switched banks late, or kept reading the old bank, would still report those flags as valid. It counts the length of the `busy` window, which exposes an off-by-one in the wipe counter as 1023 or 1025 cycles. It issues a second flush partway through the wipe and probes lookups on both sides of the switch edge. A design that dropped the held request, or switched early onto a bank that was not fully clean, would show stale ones or a gap in `busy`. It also writes on the same cycle as a flush, and it resets the block in the middle of a wipe.

// File: rtl/vbf_pkg.sv
package vbf_pkg;
  // Which bank is currently active for lookups and writes
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_sel_t;
endpackage

// File: rtl/vbf_bank.sv
module vbf_bank #(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (wr_en)  flags[wr_idx]  <= wr_val;
      if (clr_en) flags[clr_idx] <= 1'b0;  // wipe wins on overlap
    end
  end

  assign rd_bit = flags[rd_idx];
endmodule

// File: rtl/vbf_sweep.sv
module vbf_sweep
  import vbf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_req,
  output bank_sel_t        act_sel,
  output logic             clr_on,
  output logic [IDX_W-1:0] clr_ptr,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= BANK_A;
      clr_on  <= 1'b0;
      clr_ptr <= '0;
      held    <= 1'b0;
    end else if (!clr_on) begin
      if (flush_req) begin
        act_sel <= bank_sel_t'(~act_sel);
        clr_on  <= 1'b1;
        clr_ptr <= '0;
      end
    end else begin
      clr_ptr <= clr_ptr + 1'b1;
      if (clr_ptr == LAST) begin
        if (held || flush_req) begin
          // old bank is now fully clean: switch onto it and wipe the other
          act_sel <= bank_sel_t'(~act_sel);
          held    <= 1'b0;
        end else begin
          clr_on  <= 1'b0;
        end
      end else if (flush_req) begin
        held <= 1'b1;
      end
    end
  end

  assign busy = clr_on | held;
endmodule

// File: rtl/vbank_flush_ctrl.sv
module vbank_flush_ctrl
  import vbf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic             flush_req,
  output logic             busy
);
  localparam int NBANK = 2;

  bank_sel_t        act_sel;
  logic             clr_on;
  logic [IDX_W-1:0] clr_ptr;
  logic [NBANK-1:0] rd_bits;

  vbf_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_req (flush_req),
    .act_sel   (act_sel),
    .clr_on    (clr_on),
    .clr_ptr   (clr_ptr),
    .busy      (busy)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic is_act;
    assign is_act = (act_sel == bank_sel_t'(b));
    vbf_bank #(.IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en & is_act),
      .wr_idx  (wr_idx),
      .wr_val  (wr_val),
      .clr_en  (clr_on & ~is_act),
      .clr_idx (clr_ptr),
      .rd_idx  (lk_idx),
      .rd_bit  (rd_bits[b])
    );
  end

  assign lk_valid = rd_bits[act_sel];
endmodule

// File: rtl/vbank_flush_chk.sv
module vbank_flush_chk
  import vbf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] lk_idx,
  input logic             lk_valid,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_val,
  input logic             flush_req,
  input logic             busy,
  input bank_sel_t        act_sel
);
  // R3: an idle flush empties the view on the very next cycle
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy) |=> !lk_valid);

  // R4: an idle flush starts the background wipe
  a_r4_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy) |=> busy);

  // R4: with no request, an idle block stays idle
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_req && !busy) |=> !busy);

  // R6: a request during a wipe keeps busy asserted
  a_r6_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && busy) |=> busy);

  // R2: a write is visible next cycle unless the bank switched
  a_r2_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (act_sel != $past(act_sel) || lk_idx != $past(wr_idx)
               || lk_valid == $past(wr_val)));
endmodule

bind vbank_flush_ctrl vbank_flush_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_idx    (lk_idx),
  .lk_valid  (lk_valid),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_val    (wr_val),
  .flush_req (flush_req),
  .busy      (busy),
  .act_sel   (act_sel)
);

// File: tb/tb_vbank_flush_ctrl.sv
module tb_vbank_flush_ctrl;
  localparam int IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;
  // vector: {is_write, idx[9:0], value, expected}
  localparam int NVEC = 10;
  localparam logic [12:0] VEC [0:NVEC-1] = '{
    {1'b1, 10'd3,    1'b1, 1'b0},
    {1'b1, 10'd1023, 1'b1, 1'b0},
    {1'b1, 10'd0,    1'b1, 1'b0},
    {1'b0, 10'd3,    1'b0, 1'b1},
    {1'b0, 10'd1023, 1'b0, 1'b1},
    {1'b0, 10'd0,    1'b0, 1'b1},
    {1'b0, 10'd7,    1'b0, 1'b0},
    {1'b1, 10'd3,    1'b0, 1'b0},
    {1'b0, 10'd3,    1'b0, 1'b0},
    {1'b0, 10'd1022, 1'b0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] lk_idx = '0;
  logic             lk_valid;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic             wr_val = 1'b0;
  logic             flush_req = 1'b0;
  logic             busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vbank_flush_ctrl #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_valid(lk_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .flush_req(flush_req), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(input string req, input int idx, input int exp);
    lk_idx = IDX_W'(idx);
    #1;
    chk(req, int'(lk_valid), exp);
  endtask

  // each task starts and ends just after a falling edge
  task automatic wr(input int idx, input logic v);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_val = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flush();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    look("R1", 0, 0);
    look("R1", 1023, 0);

    // R2: table of writes and lookups
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][12]) wr(int'(VEC[i][11:2]), VEC[i][1]);
      else look("R2", int'(VEC[i][11:2]), int'(VEC[i][0]));
    end

    // R3: flush while idle
    flush();
    look("R3", 1023, 0);
    look("R3", 0, 0);
    chk("R4 busy rise", int'(busy), 1);

    // R4: busy window length with no second flush
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
    chk("R4 window", n, DEPTH);

    // R5: writes on the new bank during a wipe
    flush();
    wr(5, 1'b1);
    look("R5", 5, 1);
    // R6: second flush during the wipe is held
    flush();
    n = 0;
    while (busy && n < 5000) begin
      if (n == 1021) look("R6 before switch", 5, 1);
      if (n == 1022) begin
        look("R6 after switch", 5, 0);
        look("R7", 1023, 0);
        look("R7", 0, 0);
      end
      n++;
      @(negedge clk);
    end
    chk("R6 window", n, 2 * DEPTH - 2);

    // R8: write on the flush cycle is not visible afterwards
    wr_en = 1'b1; wr_idx = IDX_W'(9); wr_val = 1'b1;
    flush();
    wr_en = 1'b0;
    look("R8", 9, 0);
    look("R7", 5, 0);

    // R1: reset during a wipe
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    wr(9, 1'b1);
    look("R1 bank A after reset", 9, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule